// File: doc/BRIEF.md
# Sixteen-Entry Operand Register Bank with Zero-Base Gating

This block keeps sixteen 32-bit working registers and picks operands for them straight from a 32-bit instruction word. Three 4-bit register fields sit in the word: the first operand field at bits 26..23, the second at bits 22..19 and the third at bits 18..15. A code of 0000 names register 0 and 1111 names register 15. Register 14 serves as the stack pointer and register 15 keeps the return address of a jump-and-link. The control sequencer raises one strobe per cycle. One of the three field strobes puts the named register on the read bus. When write-enable is also high, that same strobe names the register that takes the write bus at the next rising clock edge.

A fourth strobe, the base strobe, reads the register named by the second field for use as the base of an address or immediate sum. When that field is 0000 the read bus carries zero rather than the contents of register 0. A single opcode can therefore cover both direct addressing (constant only) and indexed addressing (register plus constant). The block also gives the low 19 bits of the word, sign-extended to 32 bits, to the address adder. The opcode bits 31..27 and the unused bits 14..0 play no part in register selection.

Both buses are plain strobe-qualified buses and have no back-pressure. A write offered with a field strobe and write-enable is always taken at that edge. Read data is valid during the same cycle as the strobe. The sequencer must therefore never present more than one strobe at a time.

Top module: `gpr_bank`

## Requirements
- R1: A synchronous reset (rst high at a rising edge) clears all sixteen registers to zero, and every register reads zero afterwards until it is written.
- R2: With pick_a high, rd_bus shows the register whose index is instr_word[26:23].
- R3: With pick_b high, rd_bus shows the register whose index is instr_word[22:19].
- R4: With pick_c high, rd_bus shows the register whose index is instr_word[18:15].
- R5: At most one of pick_a, pick_b, pick_c, pick_base may be high in a cycle. With wr_en high and a field strobe high, wr_bus is stored at the rising edge into the register that strobe selects and is readable from the next cycle. With wr_en low, no register changes.
- R6: With pick_base high and instr_word[22:19] = 0000, rd_bus is all zeros even when register 0 holds a nonzero value. Register 0 itself is writable and reads its stored value through pick_a, pick_b or pick_c.
- R7: With pick_base high and instr_word[22:19] nonzero, rd_bus shows the register that field names.
- R8: const_ext equals instr_word[18:0] with bit 18 copied into bits 31..19, at all times.
- R9: With no strobe high, rd_bus is zero. A write with wr_en high and no field strobe, or with only pick_base, changes no register.
- R10: The opcode bits 31..27 and bits 14..0 do not change which register is selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| instr_word | input | 32 | Instruction word holding the register fields and constant |
| pick_a | input | 1 | Select register named by bits 26..23 |
| pick_b | input | 1 | Select register named by bits 22..19 |
| pick_c | input | 1 | Select register named by bits 18..15 |
| pick_base | input | 1 | Read bits 22..19 register as a base, zero when code is 0000 |
| wr_en | input | 1 | Store wr_bus into the strobe-selected register at the edge |
| wr_bus | input | 32 | Write data |
| rd_bus | output | 32 | Read data for the active strobe |
| const_ext | output | 32 | Sign-extended 19-bit constant |

## Verification
Reads and the constant are combinational: rd_bus and const_ext are due in the same cycle as the strobe and word. The bench drives inputs at the falling edge and samples shortly after, before the next rising edge. A write takes effect at the first rising edge with wr_en high and is first seen in the following cycle. The bench updates its own register model only after that edge and reads back in a later cycle. Reset is likewise checked by reading all sixteen registers in the cycles after rst is released.

// File: rtl/gpr_pkg.sv
package gpr_pkg;
  localparam int DEF_W      = 32;
  localparam int DEF_NREG   = 16;
  localparam int DEF_IMM_W  = 19;
  localparam int DEF_FA_LSB = 23;
  localparam int DEF_FB_LSB = 19;
  localparam int DEF_FC_LSB = 15;

  typedef enum logic [2:0] {
    SRC_NONE = 3'd0,
    SRC_A    = 3'd1,
    SRC_B    = 3'd2,
    SRC_C    = 3'd3,
    SRC_BASE = 3'd4
  } src_e;
endpackage

// File: rtl/gpr_sel_decode.sv
module gpr_sel_decode
  import gpr_pkg::*;
#(
  parameter int NREG = DEF_NREG,
  localparam int SELW = $clog2(NREG)
) (
  input  logic [SELW-1:0] fld_a,
  input  logic [SELW-1:0] fld_b,
  input  logic [SELW-1:0] fld_c,
  input  logic            pick_a,
  input  logic            pick_b,
  input  logic            pick_c,
  input  logic            pick_base,
  input  logic            wr_en,
  output logic [NREG-1:0] rd_oh,
  output logic [NREG-1:0] wr_oh
);
  src_e            src;
  logic [SELW-1:0] idx;
  logic            zero_gate;
  logic [NREG-1:0] sel_oh;

  always_comb begin
    src = SRC_NONE;
    idx = '0;
    if (pick_base) begin
      src = SRC_BASE;
      idx = fld_b;
    end else if (pick_a) begin
      src = SRC_A;
      idx = fld_a;
    end else if (pick_b) begin
      src = SRC_B;
      idx = fld_b;
    end else if (pick_c) begin
      src = SRC_C;
      idx = fld_c;
    end
  end

  genvar k;
  generate
    for (k = 0; k < NREG; k++) begin : g_oh
      assign sel_oh[k] = (src != SRC_NONE) && (idx == SELW'(k));
    end
  endgenerate

  assign zero_gate = (src == SRC_BASE) && (fld_b == '0);
  assign rd_oh     = zero_gate ? '0 : sel_oh;
  assign wr_oh     = (wr_en && src != SRC_BASE) ? sel_oh : '0;
endmodule

// File: rtl/gpr_storage.sv
module gpr_storage
  import gpr_pkg::*;
#(
  parameter int W    = DEF_W,
  parameter int NREG = DEF_NREG
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [NREG-1:0]          wr_oh,
  input  logic [W-1:0]             wr_bus,
  output logic [NREG-1:0][W-1:0]   q
);
  genvar k;
  generate
    for (k = 0; k < NREG; k++) begin : g_reg
      always_ff @(posedge clk) begin
        if (rst)            q[k] <= '0;
        else if (wr_oh[k])  q[k] <= wr_bus;
      end

      // R5
      wr_lands_chk: assert property (@(posedge clk) disable iff (rst)
        wr_oh[k] |=> (q[k] == $past(wr_bus)));

      // R5
      hold_chk: assert property (@(posedge clk) disable iff (rst)
        !wr_oh[k] |=> $stable(q[k]));

      // R1
      clear_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (q[k] == '0));
    end
  endgenerate
endmodule

// File: rtl/gpr_read_mux.sv
module gpr_read_mux
  import gpr_pkg::*;
#(
  parameter int W    = DEF_W,
  parameter int NREG = DEF_NREG
) (
  input  logic [NREG-1:0][W-1:0] q,
  input  logic [NREG-1:0]        rd_oh,
  output logic [W-1:0]           rd_bus
);
  always_comb begin
    rd_bus = '0;
    for (int k = 0; k < NREG; k++) begin
      rd_bus = rd_bus | (q[k] & {W{rd_oh[k]}});
    end
  end
endmodule

// File: rtl/gpr_bank.sv
module gpr_bank
  import gpr_pkg::*;
#(
  parameter int W      = DEF_W,
  parameter int NREG   = DEF_NREG,
  parameter int IMM_W  = DEF_IMM_W,
  parameter int FA_LSB = DEF_FA_LSB,
  parameter int FB_LSB = DEF_FB_LSB,
  parameter int FC_LSB = DEF_FC_LSB
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [31:0]  instr_word,
  input  logic         pick_a,
  input  logic         pick_b,
  input  logic         pick_c,
  input  logic         pick_base,
  input  logic         wr_en,
  input  logic [W-1:0] wr_bus,
  output logic [W-1:0] rd_bus,
  output logic [W-1:0] const_ext
);
  localparam int SELW = $clog2(NREG);

  logic [SELW-1:0]        fld_a, fld_b, fld_c;
  logic [NREG-1:0]        rd_oh, wr_oh;
  logic [NREG-1:0][W-1:0] q;
  logic                   unused_bits;

  assign fld_a = instr_word[FA_LSB +: SELW];
  assign fld_b = instr_word[FB_LSB +: SELW];
  assign fld_c = instr_word[FC_LSB +: SELW];
  assign unused_bits = ^instr_word[31:FA_LSB+SELW];

  assign const_ext = {{(W-IMM_W){instr_word[IMM_W-1]}}, instr_word[IMM_W-1:0]};

  gpr_sel_decode #(.NREG(NREG)) u_dec (
    .fld_a(fld_a), .fld_b(fld_b), .fld_c(fld_c),
    .pick_a(pick_a), .pick_b(pick_b), .pick_c(pick_c),
    .pick_base(pick_base), .wr_en(wr_en),
    .rd_oh(rd_oh), .wr_oh(wr_oh)
  );

  gpr_storage #(.W(W), .NREG(NREG)) u_store (
    .clk(clk), .rst(rst), .wr_oh(wr_oh), .wr_bus(wr_bus), .q(q)
  );

  gpr_read_mux #(.W(W), .NREG(NREG)) u_mux (
    .q(q), .rd_oh(rd_oh), .rd_bus(rd_bus)
  );

  // R5
  one_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    $countones({pick_a, pick_b, pick_c, pick_base}) <= 1);

  // R6
  base_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (pick_base && fld_b == '0) |-> (rd_bus == '0));

  // R9
  idle_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !(pick_a || pick_b || pick_c || pick_base) |-> (rd_bus == '0));

  // R8
  sign_fill_chk: assert property (@(posedge clk) disable iff (rst)
    ($countones(const_ext[W-1:IMM_W-1]) == 0) ||
    ($countones(const_ext[W-1:IMM_W-1]) == W-IMM_W+1));
endmodule

// File: tb/gpr_bank_tb.sv
module gpr_bank_tb;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] instr_word = '0;
  logic        pick_a = 0, pick_b = 0, pick_c = 0, pick_base = 0, wr_en = 0;
  logic [31:0] wr_bus = '0;
  logic [31:0] rd_bus, const_ext;

  always #(CLK_P/2) clk = ~clk;

  gpr_bank u_dut (
    .clk(clk), .rst(rst), .instr_word(instr_word),
    .pick_a(pick_a), .pick_b(pick_b), .pick_c(pick_c), .pick_base(pick_base),
    .wr_en(wr_en), .wr_bus(wr_bus), .rd_bus(rd_bus), .const_ext(const_ext)
  );

  logic [31:0] mdl [16];
  string       q_req [$];
  logic [31:0] q_exp [$];
  bit          q_imm [$];
  int          n_run = 0, n_fail = 0;
  bit          finished = 0;
  event        smp_ev;

  // which: 0 none, 1 field A, 2 field B, 3 field C, 4 base
  function automatic logic [31:0] mk(input int which, input logic [3:0] code,
                                     input logic [4:0] op, input logic [14:0] lo);
    logic [3:0] a, b, c;
    a = ~code; b = ~code; c = ~code;
    if (which == 1) a = code;
    if (which == 2 || which == 4) b = code;
    if (which == 3) c = code;
    return {op, a, b, c, lo};
  endfunction

  task automatic set_strobes(input int which);
    pick_a    = (which == 1);
    pick_b    = (which == 2);
    pick_c    = (which == 3);
    pick_base = (which == 4);
  endtask

  task automatic probe_w(input logic [31:0] w, input int which,
                         input logic [31:0] exp, input string req, input bit imm);
    @(negedge clk);
    instr_word = w;
    set_strobes(which);
    wr_en = 0;
    q_req.push_back(req);
    q_exp.push_back(exp);
    q_imm.push_back(imm);
    #2 -> smp_ev;
  endtask

  task automatic probe(input int which, input logic [3:0] code,
                       input logic [31:0] exp, input string req);
    probe_w(mk(which, code, 5'h1A, 15'h5A5A), which, exp, req, 1'b0);
  endtask

  task automatic wr(input int which, input logic [3:0] code,
                    input logic [31:0] data, input bit we);
    @(negedge clk);
    instr_word = mk(which, code, 5'h07, 15'h2B3C);
    set_strobes(which);
    wr_en  = we;
    wr_bus = data;
    @(posedge clk);
    if (we && which >= 1 && which <= 3) mdl[code] = data;
    #1;
    set_strobes(0);
    wr_en = 0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1;
    repeat (2) @(negedge clk);
    rst = 0;
    for (int k = 0; k < 16; k++) mdl[k] = '0;
  endtask

  function automatic logic [31:0] sx(input logic [31:0] w);
    return {{13{w[18]}}, w[18:0]};
  endfunction

  // monitor: pops expected items and compares
  initial begin
    forever begin
      string       req;
      logic [31:0] exp, act;
      bit          imm;
      @(smp_ev);
      req = q_req.pop_front();
      exp = q_exp.pop_front();
      imm = q_imm.pop_front();
      act = imm ? const_ext : rd_bus;
      n_run++;
      if (act !== exp) begin
        n_fail++;
        $display("FAIL %s: actual=%08h expected=%08h", req, act, exp);
      end
    end
  end

  initial begin
    #(CLK_P * 200000);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: actual=running expected=done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < 16; k++) mdl[k] = 'x;
    do_reset();

    // R1: every register zero after reset
    for (int k = 0; k < 16; k++) probe(1, 4'(k), 32'h0, "R1");

    // R5: fill all registers through field A
    for (int k = 0; k < 16; k++) wr(1, 4'(k), 32'h8000_0001 + k * 32'h1111_0000, 1'b1);
    // R2 / R3 / R4: read back through each field
    for (int k = 0; k < 16; k++) probe(1, 4'(k), mdl[k], "R2");
    for (int k = 0; k < 16; k++) probe(2, 4'(k), mdl[k], "R3");
    for (int k = 0; k < 16; k++) probe(3, 4'(k), mdl[k], "R4");

    // R6: base with code 0000 gives zero, ordinary read gives R0 contents
    probe(4, 4'd0, 32'h0, "R6");
    probe(2, 4'd0, mdl[0], "R6");
    probe(1, 4'd0, mdl[0], "R6");

    // R7: base with nonzero code gives register contents
    probe(4, 4'd5, mdl[5], "R7");
    probe(4, 4'd14, mdl[14], "R7");
    probe(4, 4'd15, mdl[15], "R7");

    // R5: write through field C and field B, then read back
    wr(3, 4'd9, 32'hDEAD_BEEF, 1'b1);
    probe(1, 4'd9, 32'hDEAD_BEEF, "R5");
    wr(2, 4'd14, 32'h0000_1FF0, 1'b1);
    probe(3, 4'd14, 32'h0000_1FF0, "R5");
    // R5: wr_en low leaves the register unchanged
    wr(1, 4'd3, 32'h1234_5678, 1'b0);
    probe(1, 4'd3, mdl[3], "R5");

    // R9: idle read is zero; write with no strobe or only base changes nothing
    probe(0, 4'd3, 32'h0, "R9");
    wr(0, 4'd4, 32'hFFFF_FFFF, 1'b1);
    for (int k = 0; k < 16; k++) probe(2, 4'(k), mdl[k], "R9");
    wr(4, 4'd6, 32'hCAFE_0000, 1'b1);
    probe(1, 4'd6, mdl[6], "R9");

    // R10: opcode and low unused bits do not change selection
    probe_w({5'h00, 4'd7, 4'd0, 4'd0, 15'h0000}, 1, mdl[7], "R10", 1'b0);
    probe_w({5'h1F, 4'd7, 4'd0, 4'd0, 15'h7FFF}, 1, mdl[7], "R10", 1'b0);
    probe_w({5'h15, 4'd0, 4'd11, 4'd0, 15'h6AAA}, 2, mdl[11], "R10", 1'b0);

    // R8: sign extension of bits 18..0
    begin
      logic [31:0] w;
      w = {5'h01, 4'd2, 4'd3, 4'b0111, 15'h7FFF};
      probe_w(w, 0, sx(w), "R8", 1'b1);
      w = {5'h01, 4'd2, 4'd3, 4'b1000, 15'h0000};
      probe_w(w, 0, sx(w), "R8", 1'b1);
      w = 32'hFFFF_FFFF;
      probe_w(w, 4, sx(w), "R8", 1'b1);
      w = 32'h0004_0000;
      probe_w(w, 1, sx(w), "R8", 1'b1);
    end

    // R1: reset mid-run clears everything again
    do_reset();
    for (int k = 0; k < 16; k++) probe(3, 4'(k), 32'h0, "R1");

    @(negedge clk);
    #5;
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule